// File: doc/BRIEF.md
# Dual-Rail Precharged Bitwise Logic Slice

This block computes a bitwise logic function of two single-rail operands using a dual-rail, precharged datapath whose switching activity does not depend on the data. Every logical bit travels on a true rail and a false rail. The phase clock defines two halves of each cycle. While it is high (precharge) every rail in the datapath is forced to 0. While it is low (evaluation) exactly one rail of each bit rises, and that rail carries the answer. Every gate inside is a pair of positive gates (AND, OR and AND-OR only, with no inverter on a rail). One gate works on the true rails and its dual works on the false rails.

Operands enter through encoders that gate each bit and its complement with the evaluation phase. A 2-bit select picks XOR, AND, OR or XNOR for the whole word. The dual-rail result is visible at the ports during evaluation. A decoder turns it back to single-rail: it takes the true rail, holds it across the end of evaluation and loads it into a word register on the rising clock edge. The same decoder watches for any bit whose two rails agree during evaluation and raises a sticky fault flag.

The operands and the select are applied while the clock is high and held stable through the low phase that follows. The registered result is read after the next rising edge.

Top module: `dual_rail_slice`

## Requirements
- R1: While `clk` is high (precharge), every bit of `resT` and `resF` is 0.
- R2: While `clk` is low (evaluation), `resF` is the bitwise complement of `resT`, so exactly WIDTH rails are high across the two buses.
- R3: With `opSel` = 0, `resT` during evaluation equals `opA ^ opB`.
- R4: With `opSel` = 1, `resT` during evaluation equals `opA & opB`.
- R5: With `opSel` = 2, `resT` during evaluation equals `opA | opB`.
- R6: With `opSel` = 3, `resT` during evaluation equals `~(opA ^ opB)`. This value is obtained by exchanging the rails of the XOR pair.
- R7: On each rising edge of `clk`, `resWord` takes the `resT` value of the evaluation phase that just ended. It keeps that value through the following precharge, even if the operands change. While `rst_n` is low it is 0.
- R8: `railFault` is 0 after reset. It is set on a rising edge if, in the evaluation just ended, some bit had equal rails. Once set, it stays set until reset. With well-formed operands it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock: high = precharge, low = evaluation |
| rst_n | input | 1 | Asynchronous active-low reset of the result register and the fault flag |
| opA | input | WIDTH | First single-rail operand |
| opB | input | WIDTH | Second single-rail operand |
| opSel | input | 2 | Operation: 0 XOR, 1 AND, 2 OR, 3 XNOR |
| resT | output | WIDTH | True rails of the result |
| resF | output | WIDTH | False rails of the result |
| resWord | output | WIDTH | Single-rail result register |
| railFault | output | 1 | Sticky flag for a bit whose rails were equal during evaluation |

## Verification
The hardest point to reach is the instant the phase flips. The result has to survive the rising edge, where the rails collapse to 0 at the same moment they are captured. The bench drives new operands during every precharge, before the previous result has been read. It then checks that `resWord` still holds the earlier value during that precharge, and that it shows the new value only after the next rising edge. A near-exhaustive sweep applies every pair of 4-bit patterns, repeated across the word, under all four selects. Shifted and mixed words follow, so every bit position sees every rail combination.

// File: rtl/dual_rail_pkg.sv
package dual_rail_pkg;

  localparam int NUM_OPS = 4;

  typedef enum logic [1:0] {
    OP_XOR  = 2'd0,
    OP_AND  = 2'd1,
    OP_OR   = 2'd2,
    OP_XNOR = 2'd3
  } op_e;

  // Strobes from control to datapath and decoder
  typedef struct packed {
    logic                evalEn;  // high during evaluation phase
    logic [NUM_OPS-1:0]  opHot;   // one-hot operation, zero in precharge
  } strobe_t;

endpackage

// File: rtl/dual_rail_encoder.sv
module dual_rail_encoder #(
  parameter int WIDTH = 32
) (
  input  logic             evalEn,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] railT,
  output logic [WIDTH-1:0] railF
);

  // Each bit becomes a pair that is all-zero in precharge
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign railT[i] =  dataIn[i] & evalEn;
    assign railF[i] = ~dataIn[i] & evalEn;
  end

endmodule

// File: rtl/dual_rail_cell.sv
module dual_rail_cell
  import dual_rail_pkg::*;
(
  input  logic               aT,
  input  logic               aF,
  input  logic               bT,
  input  logic               bF,
  input  logic [NUM_OPS-1:0] opHot,
  output logic               yT,
  output logic               yF
);

  logic xorT, xorF;
  logic andT, andF;
  logic orT,  orF;

  // XOR pair: AND-OR on each side, both built from positive gates
  assign xorT = (aT & bF) | (aF & bT);
  assign xorF = (aT & bT) | (aF & bF);

  // AND on true rails is dual to OR on false rails
  assign andT = aT & bT;
  assign andF = aF | bF;

  // OR on true rails is dual to AND on false rails
  assign orT  = aT | bT;
  assign orF  = aF & bF;

  // Select is an AND-OR tree; XNOR reuses the XOR pair with rails exchanged
  assign yT = (opHot[OP_XOR]  & xorT) |
              (opHot[OP_AND]  & andT) |
              (opHot[OP_OR]   & orT)  |
              (opHot[OP_XNOR] & xorF);

  assign yF = (opHot[OP_XOR]  & xorF) |
              (opHot[OP_AND]  & andF) |
              (opHot[OP_OR]   & orF)  |
              (opHot[OP_XNOR] & xorT);

endmodule

// File: rtl/dual_rail_datapath.sv
module dual_rail_datapath
  import dual_rail_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  strobe_t          strb,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] resT,
  output logic [WIDTH-1:0] resF
);

  logic [WIDTH-1:0] aT, aF, bT, bF;

  dual_rail_encoder #(.WIDTH(WIDTH)) u_encA (
    .evalEn (strb.evalEn),
    .dataIn (opA),
    .railT  (aT),
    .railF  (aF)
  );

  dual_rail_encoder #(.WIDTH(WIDTH)) u_encB (
    .evalEn (strb.evalEn),
    .dataIn (opB),
    .railT  (bT),
    .railF  (bF)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    dual_rail_cell u_cell (
      .aT    (aT[i]),
      .aF    (aF[i]),
      .bT    (bT[i]),
      .bF    (bF[i]),
      .opHot (strb.opHot),
      .yT    (resT[i]),
      .yF    (resF[i])
    );
  end

endmodule

// File: rtl/dual_rail_control.sv
module dual_rail_control
  import dual_rail_pkg::*;
(
  input  logic       clk,
  input  logic [1:0] opSel,
  output strobe_t    strb
);

  logic evalPhase;

  assign evalPhase = ~clk;

  always_comb begin
    strb.evalEn = evalPhase;
    strb.opHot  = '0;
    for (int k = 0; k < NUM_OPS; k++) begin
      if (opSel == k[1:0]) strb.opHot[k] = evalPhase;
    end
  end

endmodule

// File: rtl/dual_rail_decoder.sv
module dual_rail_decoder
  import dual_rail_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strb,
  input  logic [WIDTH-1:0] resT,
  input  logic [WIDTH-1:0] resF,
  output logic [WIDTH-1:0] resWord,
  output logic             railFault
);

  logic [WIDTH-1:0] holdT;
  logic             holdBad;
  logic             badNow;

  // A bit is malformed when both rails agree
  assign badNow = |(~(resT ^ resF));

  // Transparent only in evaluation, so it closes before the rails collapse
  always_latch begin
    if (strb.evalEn) begin
      holdT   = resT;
      holdBad = badNow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resWord   <= '0;
      railFault <= 1'b0;
    end else begin
      resWord   <= holdT;
      railFault <= railFault | holdBad;
    end
  end

endmodule

// File: rtl/dual_rail_slice.sv
module dual_rail_slice
  import dual_rail_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [1:0]       opSel,
  output logic [WIDTH-1:0] resT,
  output logic [WIDTH-1:0] resF,
  output logic [WIDTH-1:0] resWord,
  output logic             railFault
);

  strobe_t strb;

  dual_rail_control u_ctrl (
    .clk   (clk),
    .opSel (opSel),
    .strb  (strb)
  );

  dual_rail_datapath #(.WIDTH(WIDTH)) u_dp (
    .strb (strb),
    .opA  (opA),
    .opB  (opB),
    .resT (resT),
    .resF (resF)
  );

  dual_rail_decoder #(.WIDTH(WIDTH)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .resT      (resT),
    .resF      (resF),
    .resWord   (resWord),
    .railFault (railFault)
  );

endmodule

// File: rtl/dual_rail_slice_chk.sv
module dual_rail_slice_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [1:0]       opSel,
  input logic [WIDTH-1:0] resT,
  input logic [WIDTH-1:0] resF,
  input logic [WIDTH-1:0] resWord,
  input logic             railFault
);

  // Sampled values at a falling edge belong to the precharge phase
  // R1
  precharge_zero_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (resT == '0) && (resF == '0));

  // Sampled values at a rising edge belong to the evaluation phase
  // R2
  complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resF == ~resT) && ($countones({resT, resF}) == WIDTH));

  // R3
  xor_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opSel == 2'd0) |-> (resT == (opA ^ opB)));

  // R4
  and_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opSel == 2'd1) |-> (resT == (opA & opB)));

  // R5
  or_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opSel == 2'd2) |-> (resT == (opA | opB)));

  // R6
  xnor_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opSel == 2'd3) |-> (resT == ~(opA ^ opB)));

  // R7
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (resWord == $past(resT)));

  // R8
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    railFault |=> railFault);

  // R8
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resF == ~resT) |=> !railFault);

endmodule

bind dual_rail_slice dual_rail_slice_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/dual_rail_slice_bench.sv
`timescale 1ns/1ps
module dual_rail_slice_bench;

  localparam int W = 32;

  logic         clk = 1'b1;
  logic         rst_n = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [1:0]   opSel = 2'd0;
  logic [W-1:0] resT, resF, resWord;
  logic         railFault;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [W-1:0] lastExp = '0;

  always #5 clk = ~clk;

  dual_rail_slice #(.WIDTH(W)) u_dual_rail_slice (
    .clk, .rst_n, .opA, .opB, .opSel, .resT, .resF, .resWord, .railFault
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(input logic [1:0] s, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    case (s)
      2'd0:    return a ^ b;
      2'd1:    return a & b;
      2'd2:    return a | b;
      default: return ~(a ^ b);
    endcase
  endfunction

  function automatic string opTag(input logic [1:0] s);
    case (s)
      2'd0:    return "R3 xor";
      2'd1:    return "R4 and";
      2'd2:    return "R5 or";
      default: return "R6 xnor";
    endcase
  endfunction

  // Entered 1 ns after a rising edge; returns 1 ns after the next one
  task automatic runOp(input logic [1:0] s, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] exp;
    exp = model(s, a, b);
    opA = a; opB = b; opSel = s;
    #2;
    // R1: precharge, rails low
    chk("R1 precharge true", resT, '0);
    chk("R1 precharge false", resF, '0);
    // R7: earlier result held while new operands sit at the inputs
    chk("R7 hold", resWord, lastExp);
    @(negedge clk); #2;
    chk(opTag(s), resT, exp);
    // R2: rails complementary in evaluation
    chk("R2 complement", resF, ~exp);
    @(posedge clk); #1;
    chk("R7 capture", resWord, exp);
    // R8: no fault for well-formed rails
    chk("R8 fault", {{(W-1){1'b0}}, railFault}, '0);
    lastExp = exp;
  endtask

  initial begin
    #3;
    chk("R7 reset word", resWord, '0);
    chk("R8 reset fault", {{(W-1){1'b0}}, railFault}, '0);
    #9 rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R7 word after release", resWord, '0);
    lastExp = '0;
    // Every pair of 4-bit patterns, repeated across the word, under every select
    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          runOp(s[1:0], {8{a[3:0]}}, {8{b[3:0]}});
        end
      end
    end
    // Mixed words: shifted ones against arithmetic patterns
    for (int i = 0; i < W; i++) begin
      for (int s = 0; s < 4; s++) begin
        runOp(s[1:0], 32'h1 << i, 32'h9E37_79B9 * (i + 1));
        runOp(s[1:0], ~(32'h1 << i), 32'hA5C3_0F96 ^ (32'h0101_0101 * i));
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule